// File: doc/BRIEF.md
# Per-Source Interrupt Event State Buffer

This block holds a two-bit pending/queued state for each of a set of interrupt sources. Software and devices reach it through memory-mapped pages. The action an access takes depends on three things: whether it is a load or a store, which page it hits (the management page or the trigger page), and its offset within that page. The written data plays no part.

Some loads on the management page change the state and return the state held before the access. A store to the trigger page fires the source. End-of-interrupt can be done by a store or by a load, and it can re-arm a fire that arrived while the source was still pending. When a fire must go on to the routing logic, the block raises a one-cycle notify pulse that carries the source index.

Each source is a small four-state machine:

- `PQ_IDLE` (00): no pending event, source enabled.
- `PQ_OFF` (01): source masked.
- `PQ_PEND` (10): one event forwarded and not yet ended.
- `PQ_PEND_Q` (11): pending, with a further event queued behind it.

The transitions are named by the operation that causes them:

- `OP_TRIG`: fire the source.
- `OP_EOI`: end of interrupt.
- `OP_UNMASK`: force the state to 00.
- `OP_MASK`: force the state to 01.
- `OP_NONE`: hold the state.

In the returned state value, P is bit 1 and Q is bit 0.

Top module: `pq_event_buffer`

## Requirements
- R1: After reset every source is in `PQ_OFF` (01), and `rsp_valid` and `notify_valid` are low.
- R2: A load on the management page at offset 0xC00 returns the old state in `rsp_data[1:0]` (P in bit 1, Q in bit 0, all other bits zero) one cycle later, and moves the source to `PQ_IDLE`. It never notifies.
- R3: A load on the management page at offset 0xD00 returns the old state in the same form and moves the source to `PQ_OFF`. It never notifies.
- R4: A store to the trigger page at any offset fires the source. 00 moves to 10 and notifies. 10 or 11 moves to 11 with no notify. 01 stays at 01 with no notify.
- R5: A store on the management page at offset 0x400 is an end of interrupt. It clears P. If Q was set, Q is also cleared, the state becomes 10 and a notify is raised. Otherwise the state becomes 00.
- R6: A load on the management page at offset 0x000 returns the old state and applies the end-of-interrupt transition of R5, including its notify.
- R7: A load at any other management-page offset, and any load on the trigger page, returns all ones in `rsp_data` and leaves the state unchanged.
- R8: A store on the management page at any offset other than 0x400 changes no state, raises no notify and gives no response.
- R9: Responses and notifies appear exactly one cycle after the access. `notify_src` gives the source index. Stores never produce `rsp_valid`.
- R10: An access to one source leaves every other source's state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_trig_page | input | 1 | 1 = trigger page, 0 = management page |
| req_src | input | SRC_W | Source index |
| req_offset | input | OFS_W | Byte offset within the page |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Old state (zero-extended) or all ones |
| notify_valid | output | 1 | Forward an event to routing |
| notify_src | output | SRC_W | Source of the forwarded event |

## Verification
The state machine is driven from every one of its four states with each of the two fire paths (trigger-page store and end of interrupt). This separates a fresh notify from a queued fire and from the masked case. Repeated fires on a pending source check that only one notify escapes while Q absorbs the rest. Store-based and load-based end of interrupt are both applied to the queued, pending and masked states, which shows whether the re-arm notify depends on Q alone. Undefined offsets, loads on the trigger page and stray management stores are each followed by a state-returning load, so any hidden change of state shows up at the ports. A final sweep over all sources confirms that untouched sources kept their reset state.

// File: rtl/pq_esb_pkg.sv
package pq_esb_pkg;

    // Two-bit event state: bit 1 = P (pending), bit 0 = Q (queued/masked)
    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_OFF    = 2'b01,
        PQ_PEND   = 2'b10,
        PQ_PEND_Q = 2'b11
    } pq_state_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_TRIG   = 3'd1,
        OP_EOI    = 3'd2,
        OP_UNMASK = 3'd3,
        OP_MASK   = 3'd4
    } esb_op_e;

    // Offsets whose meaning the state machine depends on
    localparam logic [11:0] OFS_LOAD_EOI  = 12'h000;
    localparam logic [11:0] OFS_STORE_EOI = 12'h400;
    localparam logic [11:0] OFS_UNMASK    = 12'hC00;
    localparam logic [11:0] OFS_MASK      = 12'hD00;

endpackage

// File: rtl/pq_esb_decode.sv
module pq_esb_decode
    import pq_esb_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             is_store,
    input  logic             trig_page,
    input  logic [OFS_W-1:0] offset,
    output esb_op_e          op,
    output logic             undef_load
);

    localparam logic [OFS_W-1:0] K_LOAD_EOI  = OFS_W'(OFS_LOAD_EOI);
    localparam logic [OFS_W-1:0] K_STORE_EOI = OFS_W'(OFS_STORE_EOI);
    localparam logic [OFS_W-1:0] K_UNMASK    = OFS_W'(OFS_UNMASK);
    localparam logic [OFS_W-1:0] K_MASK      = OFS_W'(OFS_MASK);

    always_comb begin
        op         = OP_NONE;
        undef_load = 1'b0;
        if (trig_page) begin
            // any store fires; loads carry no meaning here
            if (is_store) op = OP_TRIG;
            else          undef_load = 1'b1;
        end else if (is_store) begin
            if (offset == K_STORE_EOI) op = OP_EOI;
        end else begin
            unique case (offset)
                K_LOAD_EOI: op = OP_EOI;
                K_UNMASK:   op = OP_UNMASK;
                K_MASK:     op = OP_MASK;
                default:    undef_load = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pq_esb_cell.sv
module pq_esb_cell
    import pq_esb_pkg::*;
#(
    parameter pq_state_e RESET_PQ = PQ_OFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  esb_op_e   op,
    output pq_state_e pq,
    output logic      fire
);

    pq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_PQ;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (hit) begin
            unique case (op)
                OP_TRIG: begin
                    unique case (state_q)
                        PQ_IDLE:   state_d = PQ_PEND;
                        PQ_OFF:    state_d = PQ_OFF;
                        PQ_PEND:   state_d = PQ_PEND_Q;
                        PQ_PEND_Q: state_d = PQ_PEND_Q;
                        default:   state_d = state_q;
                    endcase
                end
                OP_EOI: begin
                    unique case (state_q)
                        PQ_IDLE:   state_d = PQ_IDLE;
                        PQ_OFF:    state_d = PQ_PEND;
                        PQ_PEND:   state_d = PQ_IDLE;
                        PQ_PEND_Q: state_d = PQ_PEND;
                        default:   state_d = state_q;
                    endcase
                end
                OP_UNMASK: state_d = PQ_IDLE;
                OP_MASK:   state_d = PQ_OFF;
                default:   state_d = state_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        if (hit) begin
            unique case (op)
                OP_TRIG: fire = (state_q == PQ_IDLE);
                OP_EOI:  fire = (state_q == PQ_OFF) || (state_q == PQ_PEND_Q);
                default: fire = 1'b0;
            endcase
        end
    end

    assign pq = state_q;

endmodule

// File: rtl/pq_esb_resp.sv
module pq_esb_resp
    import pq_esb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok,
    input  logic              undef_load,
    input  pq_state_e         old_pq,
    input  logic              fire_any,
    input  logic [SRC_W-1:0]  src,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              notify_valid,
    output logic [SRC_W-1:0]  notify_src
);

    logic [DATA_W-1:0] data_d;

    always_comb begin
        if (undef_load) data_d = '1;
        else            data_d = DATA_W'(old_pq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            notify_valid <= 1'b0;
            notify_src   <= '0;
        end else begin
            rsp_valid    <= load_ok;
            rsp_data     <= load_ok ? data_d : '0;
            notify_valid <= fire_any;
            notify_src   <= src;
        end
    end

endmodule

// File: rtl/pq_event_buffer.sv
module pq_event_buffer
    import pq_esb_pkg::*;
#(
    parameter int        NUM_SRC  = 8,
    parameter int        DATA_W   = 64,
    parameter int        OFS_W    = 12,
    parameter int        SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter pq_state_e RESET_PQ = PQ_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_trig_page,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [OFS_W-1:0]  req_offset,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              notify_valid,
    output logic [SRC_W-1:0]  notify_src
);

    esb_op_e           op;
    logic              dec_undef;
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] fire;
    pq_state_e         pq_vec [NUM_SRC];
    pq_state_e         old_pq;
    logic              src_ok;
    logic              load_ok;
    logic              undef_all;

    pq_esb_decode #(.OFS_W(OFS_W)) u_decode (
        .is_store   (req_write),
        .trig_page  (req_trig_page),
        .offset     (req_offset),
        .op         (op),
        .undef_load (dec_undef)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        assign hit[g] = req_valid && (req_src == SRC_W'(g));
        pq_esb_cell #(.RESET_PQ(RESET_PQ)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[g]),
            .op    (op),
            .pq    (pq_vec[g]),
            .fire  (fire[g])
        );
    end

    always_comb begin
        old_pq = PQ_OFF;
        src_ok = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (hit[i]) begin
                old_pq = pq_vec[i];
                src_ok = 1'b1;
            end
        end
    end

    assign load_ok   = req_valid && !req_write;
    assign undef_all = dec_undef || !src_ok;

    pq_esb_resp #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_ok      (load_ok),
        .undef_load   (undef_all),
        .old_pq       (old_pq),
        .fire_any     (|fire),
        .src          (req_src),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .notify_valid (notify_valid),
        .notify_src   (notify_src)
    );

endmodule

// File: rtl/pq_esb_checker.sv
module pq_esb_checker #(
    parameter int DATA_W = 64,
    parameter int OFS_W  = 12,
    parameter int SRC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_trig_page,
    input logic [SRC_W-1:0]  req_src,
    input logic [OFS_W-1:0]  req_offset,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              notify_valid,
    input logic [SRC_W-1:0]  notify_src
);

    localparam logic [OFS_W-1:0] C_STORE_EOI = OFS_W'(12'h400);
    localparam logic [OFS_W-1:0] C_MASK      = OFS_W'(12'hD00);

    assert_rsp_from_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_store_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    assert_notify_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> ($past(req_valid) && notify_src == $past(req_src)));

    assert_trig_page_load_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_trig_page) |=> (rsp_valid && rsp_data == '1));

    assert_state_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data != '1) |-> (rsp_data[DATA_W-1:2] == '0));

    assert_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_trig_page && req_offset == C_MASK) |=> !notify_valid);

    assert_stray_store_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_trig_page && req_offset != C_STORE_EOI) |=> !notify_valid);

endmodule

bind pq_event_buffer pq_esb_checker #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .SRC_W  (SRC_W)
) u_pq_esb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_trig_page (req_trig_page),
    .req_src       (req_src),
    .req_offset    (req_offset),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .notify_valid  (notify_valid),
    .notify_src    (notify_src)
);

// File: tb/test_pq_event_buffer.sv
module test_pq_event_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int DW   = 64;
    localparam int OW   = 12;
    localparam int SW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_trig_page = 1'b0;
    logic [SW-1:0] req_src = '0;
    logic [OW-1:0] req_offset = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          notify_valid;
    logic [SW-1:0] notify_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    pq_event_buffer #(.NUM_SRC(NSRC), .DATA_W(DW), .OFS_W(OW)) i_pq_event_buffer (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_trig_page (req_trig_page), .req_src (req_src), .req_offset (req_offset),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .notify_valid (notify_valid), .notify_src (notify_src)
    );

    typedef struct {
        bit            rv;
        logic [DW-1:0] rd;
        bit            nv;
        logic [SW-1:0] ns;
        string         tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [1:0] model [NSRC];
    bit         finished = 1'b0;

    // reference model of the state machine, from the requirements
    task automatic drive(input bit act, input bit wr, input bit tp, input int src,
                         input logic [OW-1:0] ofs, input string tag);
        exp_t e;
        logic [1:0] old;
        @(negedge clk);
        req_valid     = act;
        req_write     = wr;
        req_trig_page = tp;
        req_src       = SW'(src);
        req_offset    = ofs;
        e.rv = 1'b0; e.rd = '0; e.nv = 1'b0; e.ns = SW'(src); e.tag = tag;
        if (act) begin
            old = model[src];
            if (tp) begin
                if (wr) begin
                    if (old == 2'b00) begin model[src] = 2'b10; e.nv = 1'b1; end
                    else if (old[1])  model[src] = 2'b11;
                end else begin
                    e.rv = 1'b1; e.rd = '1;
                end
            end else if (wr) begin
                if (ofs == 12'h400) begin
                    if (old[0]) begin model[src] = 2'b10; e.nv = 1'b1; end
                    else        model[src] = 2'b00;
                end
            end else begin
                e.rv = 1'b1;
                case (ofs)
                    12'h000: begin
                        e.rd = DW'(old);
                        if (old[0]) begin model[src] = 2'b10; e.nv = 1'b1; end
                        else        model[src] = 2'b00;
                    end
                    12'hC00: begin e.rd = DW'(old); model[src] = 2'b00; end
                    12'hD00: begin e.rd = DW'(old); model[src] = 2'b01; end
                    default: e.rd = '1;
                endcase
            end
        end
        sb.push_back(e);
    endtask

    task automatic ld(input int src, input logic [OW-1:0] ofs, input string tag);
        drive(1'b1, 1'b0, 1'b0, src, ofs, tag);
    endtask
    task automatic st(input int src, input logic [OW-1:0] ofs, input string tag);
        drive(1'b1, 1'b1, 1'b0, src, ofs, tag);
    endtask
    task automatic trig(input int src, input logic [OW-1:0] ofs, input string tag);
        drive(1'b1, 1'b1, 1'b1, src, ofs, tag);
    endtask
    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 0, '0, "idle");
    endtask

    // monitor: compare one scoreboard item per cycle
    initial begin
        exp_t e;
        bit ok;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                ok = (rsp_valid == e.rv) && (!e.rv || rsp_data == e.rd) &&
                     (notify_valid == e.nv) && (!e.nv || notify_src == e.ns);
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: got rsp_valid=%0b rsp_data=%h notify=%0b src=%0d, expected rsp_valid=%0b rsp_data=%h notify=%0b src=%0d",
                             e.tag, rsp_valid, rsp_data, notify_valid, notify_src,
                             e.rv, e.rd, e.nv, e.ns);
                end
            end else if (!finished && (rsp_valid || notify_valid)) begin
                checks++;
                errors++;
                $display("FAIL R9 spurious output: rsp_valid=%0b notify=%0b, expected 0 0",
                         rsp_valid, notify_valid);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSRC; i++) model[i] = 2'b01;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (rsp_valid !== 1'b0 || notify_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: rsp_valid=%0b notify=%0b, expected 0 0",
                     rsp_valid, notify_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state visible through state-returning loads
        ld(0, 12'hC00, "R1 reset state src0 via unmask");
        ld(1, 12'hD00, "R1 reset state src1 via mask");

        // R4 trigger on idle, pending, queued; various offsets
        trig(0, 12'h000, "R4 trigger idle notifies");
        trig(0, 12'h7F8, "R4 trigger pending queues");
        trig(0, 12'hFFF, "R4 trigger queued stays");
        ld(0, 12'hC00, "R2 unmask returns 11");

        // R5 store-EOI from queued, pending, idle
        trig(0, 12'h010, "R4 trigger before EOI");
        trig(0, 12'h020, "R4 queue before EOI");
        st(0, 12'h400, "R5 store EOI queued re-notifies");
        st(0, 12'h400, "R5 store EOI pending clears");
        st(0, 12'h400, "R5 store EOI idle stays");
        ld(0, 12'hD00, "R3 mask returns 00");

        // R5 on masked source, then R3 readback
        st(1, 12'h400, "R5 store EOI masked notifies");
        ld(1, 12'hD00, "R3 mask returns 10");
        trig(1, 12'h000, "R4 trigger masked silent");
        ld(1, 12'hD00, "R3 mask returns 01 after masked trigger");

        // R6 load-EOI
        ld(2, 12'hC00, "R2 unmask src2");
        trig(2, 12'h000, "R4 trigger src2");
        trig(2, 12'h000, "R4 queue src2");
        ld(2, 12'h000, "R6 load EOI queued returns 11 and notifies");
        ld(2, 12'h000, "R6 load EOI pending returns 10");
        ld(2, 12'h000, "R6 load EOI idle returns 00");

        // R7 undefined loads leave state
        trig(2, 12'h000, "R4 trigger src2 for R7");
        ld(2, 12'h123, "R7 undefined offset all ones");
        ld(2, 12'h400, "R7 load at store-EOI offset all ones");
        drive(1'b1, 1'b0, 1'b1, 2, 12'hC00, "R7 trigger page load all ones");
        ld(2, 12'hC00, "R7 state unchanged returns 10");

        // R8 stray management stores
        ld(3, 12'hC00, "R2 unmask src3");
        trig(3, 12'h000, "R4 trigger src3");
        st(3, 12'hD00, "R8 store at mask offset ignored");
        st(3, 12'hC00, "R8 store at unmask offset ignored");
        st(3, 12'h000, "R8 store at load-EOI offset ignored");
        ld(3, 12'hC00, "R8 state still 10");

        // R10 back-to-back mix across sources, then full sweep
        trig(5, 12'h000, "R10 masked src5 trigger");
        ld(6, 12'hC00, "R10 unmask src6");
        trig(6, 12'h000, "R10 trigger src6");
        ld(7, 12'h000, "R10 load EOI masked src7 notifies");
        for (int i = 0; i < NSRC; i++) ld(i, 12'hD00, "R10 sweep final state");

        idle();
        idle();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule